// File: doc/BRIEF.md
# Channelized Frequency Blanking Comparator

This block keeps a small table of sixteen frequency channels, each a multi-digit BCD number, and watches a measured BCD frequency. The measured value advances one step at a time. Each advance comes with a step strobe. When the measured value reaches a stored channel, the block requests blanking with a single pulse. An operator loads the table from switch inputs while the block is in program mode. The operator can read back any channel on a display output in either mode.

In run mode every step strobe starts a serial scan of the table, one channel per clock, with lowest index first. The measured value trails the true frequency by one step. For that reason each stored entry is lowered by one step in BCD, with the borrow rippling through every digit, before it is compared. The measured value is captured on the strobe cycle and held for the whole scan. Gating of the synthesizer output itself belongs to the caller.

Top module: `blank_cmp_top`

## Requirements
- R1: In program mode (`prog_i`=1), a cycle with `store_i`=1 writes `freq_i` into the channel addressed by `chan_i`. No other channel changes.
- R2: In run mode (`prog_i`=0), `store_i` has no effect on any channel.
- R3: A cycle with `disp_i`=1 loads the addressed channel's contents into `disp_o`, which is valid after the next clock edge. While `disp_i`=0, `disp_o` holds its value. Reading never alters a channel.
- R4: After reset every channel holds 0, `disp_o` is 0 and `blank_o` is 0.
- R5: Suppose `step_i` is sampled high at edge E0 in run mode. Then `meas_i` is captured at E0, and channel c is compared at edge E(c+1). On a match, `blank_o` is high for exactly the one cycle between E(c+1) and E(c+2).
- R6: A match means that the stored value minus one BCD unit in its least significant digit equals the captured measurement. A digit at 0 becomes 9 and borrows from the next digit (0x0200 becomes 0x0199, 0x1000 becomes 0x0999). Digit 0 occupies bits [3:0] and higher digits follow upward.
- R7: A channel holding all zeros never produces a match.
- R8: At most one pulse is produced per step, for the lowest-index matching channel, even when several channels hold the same value.
- R9: In program mode a step strobe starts no scan and `blank_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_i | input | 1 | 1 = program mode, 0 = run mode |
| store_i | input | 1 | Write request for the addressed channel |
| disp_i | input | 1 | Read-back request for the addressed channel |
| chan_i | input | 4 | Channel address from the switches |
| freq_i | input | 16 | BCD frequency from the switches, digit 0 in bits [3:0] |
| meas_i | input | 16 | Measured BCD frequency |
| step_i | input | 1 | One-cycle strobe marking a new frequency step |
| disp_o | output | 16 | Read-back channel contents |
| blank_o | output | 1 | One-cycle blank request |

## Verification
A wrong stored entry or a broken borrow shows up as a missing pulse or an extra pulse within seventeen cycles of the strobe that should have matched. A wrong scan index shows up as a pulse in the wrong cycle, because the pulse position encodes the channel. A corrupted table also appears on `disp_o` one cycle after a read-back request. A wrong first-hit flag shows as a second pulse in the same step window.

// File: rtl/blank_cmp_pkg.sv
package blank_cmp_pkg;

    localparam int unsigned DIG_W = 4;

    typedef logic [DIG_W-1:0] bcd_digit_t;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_PROG = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic       borrow;
        bcd_digit_t value;
    } dig_dec_t;

    // one BCD digit minus the incoming borrow
    function automatic dig_dec_t digit_dec(input bcd_digit_t d, input logic borrow_in);
        dig_dec_t r;
        if (!borrow_in) begin
            r.value  = d;
            r.borrow = 1'b0;
        end else if (d == '0) begin
            r.value  = bcd_digit_t'(9);
            r.borrow = 1'b1;
        end else begin
            r.value  = d - bcd_digit_t'(1);
            r.borrow = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/blank_chan_store.sv
module blank_chan_store
    import blank_cmp_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DIGITS = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned FW    = DIGITS * DIG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_addr,
    input  logic [FW-1:0]   wr_data,
    input  logic [CH_W-1:0] rd_a_addr,
    output logic [FW-1:0]   rd_a_data,
    input  logic [CH_W-1:0] rd_b_addr,
    output logic [FW-1:0]   rd_b_data
);

    // one small array per decimal digit
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_t arr [NUM_CH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    arr[i] <= '0;
                end
            end else if (wr_en) begin
                arr[wr_addr] <= wr_data[g*DIG_W +: DIG_W];
            end
        end

        assign rd_a_data[g*DIG_W +: DIG_W] = arr[rd_a_addr];
        assign rd_b_data[g*DIG_W +: DIG_W] = arr[rd_b_addr];
    end

endmodule

// File: rtl/blank_step_sub.sv
module blank_step_sub
    import blank_cmp_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned FW    = DIGITS * DIG_W
) (
    input  logic [FW-1:0] val_i,
    output logic [FW-1:0] red_o,
    output logic          zero_o
);

    logic [DIGITS:0] brw;
    assign brw[0] = 1'b1;

    // borrow ripples from the least significant digit upward
    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        dig_dec_t res;
        assign res = digit_dec(val_i[g*DIG_W +: DIG_W], brw[g]);
        assign red_o[g*DIG_W +: DIG_W] = res.value;
        assign brw[g+1] = res.borrow;
    end

    assign zero_o = (val_i == '0);

endmodule

// File: rtl/blank_scan_ctrl.sv
module blank_scan_ctrl
    import blank_cmp_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DIGITS = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned FW    = DIGITS * DIG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic            step_i,
    input  logic [FW-1:0]   meas_i,
    input  logic [FW-1:0]   ref_i,
    input  logic            ref_zero_i,
    output logic [CH_W-1:0] idx_o,
    output logic            active_o,
    output logic            blank_o
);

    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

    logic [FW-1:0]   meas_q;
    logic [CH_W-1:0] idx_q;
    logic            active_q;
    logic            hit_q;
    logic            blank_q;
    logic            at_last;
    logic            match;

    assign at_last = (idx_q == LAST_IDX);
    assign match   = active_q && !ref_zero_i && (ref_i == meas_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            meas_q   <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
            hit_q    <= 1'b0;
            blank_q  <= 1'b0;
        end else if (!run_i) begin
            idx_q    <= '0;
            active_q <= 1'b0;
            hit_q    <= 1'b0;
            blank_q  <= 1'b0;
        end else begin
            blank_q <= match && !hit_q;
            if (step_i) begin
                meas_q   <= meas_i;
                idx_q    <= '0;
                active_q <= 1'b1;
                hit_q    <= 1'b0;
            end else if (active_q) begin
                if (match) begin
                    hit_q <= 1'b1;
                end
                if (at_last) begin
                    idx_q    <= '0;
                    active_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + CH_W'(1);
                end
            end
        end
    end

    assign idx_o    = idx_q;
    assign active_o = active_q;
    assign blank_o  = blank_q;

endmodule

// File: rtl/blank_cmp_top.sv
module blank_cmp_top
    import blank_cmp_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DIGITS = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned FW    = DIGITS * DIG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_i,
    input  logic            store_i,
    input  logic            disp_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic [FW-1:0]   freq_i,
    input  logic [FW-1:0]   meas_i,
    input  logic            step_i,
    output logic [FW-1:0]   disp_o,
    output logic            blank_o
);

    op_mode_e        mode;
    logic            wr_en;
    logic [FW-1:0]   sel_data;
    logic [FW-1:0]   scan_data;
    logic [FW-1:0]   scan_red;
    logic            ref_zero;
    logic [CH_W-1:0] scan_idx;
    logic            scan_active;
    logic [FW-1:0]   disp_q;

    assign mode  = op_mode_e'(prog_i);
    assign wr_en = store_i && (mode == MODE_PROG);

    blank_chan_store #(.NUM_CH(NUM_CH), .DIGITS(DIGITS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (chan_i),
        .wr_data   (freq_i),
        .rd_a_addr (chan_i),
        .rd_a_data (sel_data),
        .rd_b_addr (scan_idx),
        .rd_b_data (scan_data)
    );

    blank_step_sub #(.DIGITS(DIGITS)) u_sub (
        .val_i  (scan_data),
        .red_o  (scan_red),
        .zero_o (ref_zero)
    );

    blank_scan_ctrl #(.NUM_CH(NUM_CH), .DIGITS(DIGITS)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .run_i      (mode == MODE_RUN),
        .step_i     (step_i),
        .meas_i     (meas_i),
        .ref_i      (scan_red),
        .ref_zero_i (ref_zero),
        .idx_o      (scan_idx),
        .active_o   (scan_active),
        .blank_o    (blank_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q <= '0;
        end else if (disp_i) begin
            disp_q <= sel_data;
        end
    end

    assign disp_o = disp_q;

endmodule

// File: rtl/blank_cmp_chk.sv
module blank_cmp_chk #(
    parameter int unsigned FW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          prog_i,
    input logic          disp_i,
    input logic [FW-1:0] disp_o,
    input logic          blank_o,
    input logic          scan_on,
    input logic          ref_zero
);

    // R3
    disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !disp_i |=> $stable(disp_o));

    // R5
    pulse_from_scan_chk: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> $past(scan_on));

    // R7
    zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_on && ref_zero) |=> !blank_o);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blank_o |=> !blank_o);

    // R9
    prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        prog_i |=> !blank_o);

endmodule

bind blank_cmp_top blank_cmp_chk #(.FW(FW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .prog_i   (prog_i),
    .disp_i   (disp_i),
    .disp_o   (disp_o),
    .blank_o  (blank_o),
    .scan_on  (scan_active),
    .ref_zero (ref_zero)
);

// File: tb/blank_cmp_top_tb.sv
`timescale 1ns/1ps
module blank_cmp_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_i = 1'b1;
    logic        store_i = 1'b0;
    logic        disp_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic [15:0] freq_i = '0;
    logic [15:0] meas_i = '0;
    logic        step_i = 1'b0;
    logic [15:0] disp_o;
    logic        blank_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected pulse offset per step window, -1 means no pulse
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    blank_cmp_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .prog_i  (prog_i),
        .store_i (store_i),
        .disp_i  (disp_i),
        .chan_i  (chan_i),
        .freq_i  (freq_i),
        .meas_i  (meas_i),
        .step_i  (step_i),
        .disp_o  (disp_o),
        .blank_o (blank_o)
    );

    // monitor: measures each step window and compares with the queue
    bit win = 1'b0;
    int since = 0;
    int pulses = 0;
    int first_at = -1;
    always @(negedge clk) begin
        if (step_i) begin
            win = 1'b1; since = 0; pulses = 0; first_at = -1;
        end else if (win) begin
            since++;
            if (blank_o) begin
                pulses++;
                if (first_at < 0) first_at = since;
            end
            if (since == 20) begin
                int    e;
                string t;
                win = 1'b0;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard: window without expectation");
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ((e < 0 && pulses != 0) || (e >= 0 && (pulses != 1 || first_at != e))) begin
                        fails++;
                        $display("FAIL %s: pulses=%0d at=%0d expected pulses=%0d at=%0d",
                                 t, pulses, first_at, (e < 0) ? 0 : 1, e);
                    end
                end
            end
        end else if (blank_o && !rst) begin
            checks++;
            fails++;
            $display("FAIL R5: pulse outside step window, got 1 expected 0");
        end
    end

    task automatic store(input logic [3:0] ch, input logic [15:0] v);
        @(posedge clk); #1;
        chan_i = ch; freq_i = v; store_i = 1'b1;
        @(posedge clk); #1;
        store_i = 1'b0;
    endtask

    task automatic show(input logic [3:0] ch, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        chan_i = ch; disp_i = 1'b1;
        @(posedge clk); #1;
        disp_i = 1'b0;
        @(negedge clk);
        checks++;
        if (disp_o !== exp) begin
            fails++;
            $display("FAIL %s: disp_o=%h expected %h", tag, disp_o, exp);
        end
    endtask

    // driver: channel c matching gives a pulse seen at window offset c+2
    task automatic step(input logic [15:0] m, input int exp_at, input string tag);
        exp_q.push_back(exp_at);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        meas_i = m; step_i = 1'b1;
        @(posedge clk); #1;
        step_i = 1'b0;
        repeat (24) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (disp_o !== 16'h0 || blank_o !== 1'b0) begin
            fails++;
            $display("FAIL R4: disp_o=%h blank_o=%b expected 0000 0", disp_o, blank_o);
        end
        show(4'd5, 16'h0000, "R4");

        // R1: program entries
        store(4'd2,  16'h2110);
        store(4'd10, 16'h0200);
        store(4'd11, 16'h1000);
        show(4'd2, 16'h2110, "R1");
        show(4'd7, 16'h0000, "R1");
        show(4'd10, 16'h0200, "R1");

        // R3: hold while disp_i low, reads do not alter
        @(posedge clk); #1 chan_i = 4'd11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (disp_o !== 16'h0200) begin
            fails++;
            $display("FAIL R3: disp_o=%h expected 0200", disp_o);
        end
        show(4'd10, 16'h0200, "R3");

        // R2: store ignored in run mode
        @(posedge clk); #1 prog_i = 1'b0;
        store(4'd2, 16'h5555);
        show(4'd2, 16'h2110, "R2");

        // R5: match and mismatch
        step(16'h2109, 4, "R5");
        step(16'h2110, -1, "R5");
        // R6: borrow across digits
        step(16'h0199, 12, "R6");
        step(16'h0999, 13, "R6");
        // R7: zero entries never match
        step(16'h9999, -1, "R7");

        // R8: duplicates give one pulse at lowest index
        @(posedge clk); #1 prog_i = 1'b1;
        store(4'd3, 16'h0150);
        store(4'd4, 16'h0150);
        store(4'd9, 16'h0150);
        @(posedge clk); #1 prog_i = 1'b0;
        step(16'h0149, 5, "R8");

        // R9: steps ignored in program mode
        @(posedge clk); #1 prog_i = 1'b1;
        step(16'h2109, -1, "R9");
        step(16'h0149, -1, "R9");

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d windows unchecked, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule